// File: doc/BRIEF.md
# Acknowledged interval interrupt timer

This block measures a fixed interval in clock cycles and raises an interrupt level when the interval runs out. A typical use is the scheduler tick of a processor: a 10 ms interval at a 50 MHz clock is 500,000 cycles. Once the interrupt is raised it stays high until the processor acknowledges it. The acknowledge lowers the line and starts a new full interval.

The timer does not reload by itself. After it expires, the count waits at its last value and the interrupt stays pending until the next acknowledge. An acknowledge may also arrive when no interrupt is pending. It then throws away the partial count and begins a fresh interval. The asynchronous active-low reset is asserted at once and released in step with the clock through a two-stage synchronizer.

Top module: `interval_irq_timer`

## Requirements
- R1: While `rst_n` is low, `irq_o` is low. After reset is released, the first interval begins once the reset synchronizer has released, two clock edges later. `irq_o` therefore rises on the (PERIOD_CYCLES+2)-th rising edge after `rst_n` goes high and is low before it.
- R2: `irq_o` rises on the PERIOD_CYCLES-th rising edge after the last edge at which `ack_i` was sampled high, and never earlier.
- R3: Once high, `irq_o` stays high on every edge at which `ack_i` is low, however long that lasts.
- R4: An edge that samples `ack_i` high drives `irq_o` low, and a new full interval of PERIOD_CYCLES edges follows.
- R5: While the interrupt is pending, the interval count holds at its final value and no new interval starts. Long waits before the acknowledge do not shorten the next interval.
- R6: An acknowledge sampled while no interrupt is pending discards the partial count and restarts the interval from zero.
- R7: An acknowledge sampled on the same edge on which the interval would expire takes priority. `irq_o` stays low and a full interval restarts.
- R8: If `ack_i` is held high for several edges, `irq_o` stays low throughout. The interval is measured from the last edge that sampled it high.
- R9: PERIOD_CYCLES may be as small as 2. With that setting, `irq_o` rises on the second edge after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ack_i | input | 1 | Acknowledge: clears a pending interrupt and restarts the interval |
| irq_o | output | 1 | Interrupt level, held high from expiry until acknowledged |

## Verification
The hardest case to reach is an acknowledge that lands on exactly the edge where the count reaches its end. Missing by one edge in either direction tests something else. The stimulus issues an acknowledge and counts PERIOD_CYCLES-1 edges from it, then raises `ack_i` for the next edge, so the acknowledge meets expiry on the same edge. A second instance built with the minimum interval of 2 exercises the case where the terminal value sits one step from zero.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // Width needed to hold counts 0 .. n-1, never less than one bit.
  function automatic int unsigned cnt_bits(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((32'd1 << w) < n) w = w + 1;
    return w;
  endfunction
endpackage

// File: rtl/tick_rst_sync.sv
module tick_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

`ifndef SYNTHESIS
  // R1: the synchronized reset never releases while the raw reset is low
  p_sync_follows_r1: assert property (@(posedge clk) !rst_n |-> !rst_sync_n);
`endif
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned PERIOD_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic at_end
);
  localparam int unsigned CNT_W = tick_pkg::cnt_bits(PERIOD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign at_end = (cnt_q == LAST);
  assign cnt_en = clear | (run & ~at_end);

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

`ifndef SYNTHESIS
  // R6: a clear always leaves the count at zero on the next cycle
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
  // R5: once at the end the count waits there until cleared
  p_hold_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !clear) |=> (at_end && $stable(cnt_q)));
  // R5: while stopped the count does not move
  p_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(cnt_q));
`endif
endmodule

// File: rtl/tick_irq_hold.sv
module tick_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic expired,
  output logic irq
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = irq_q;
    if (ack)          irq_d = 1'b0;
    else if (expired) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

`ifndef SYNTHESIS
  // R2: the line only rises after the count reached its end
  p_rise_on_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expired));
  // R3: a pending interrupt survives every cycle without acknowledge
  p_irq_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack) |=> irq_q);
  // R4 / R7: an acknowledge always lowers the line
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_q);
`endif
endmodule

// File: rtl/interval_irq_timer.sv
module interval_irq_timer #(
  parameter int unsigned PERIOD_CYCLES = 500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_i,
  output logic irq_o
);
  logic rst_int_n;
  logic at_end;
  logic irq;

  tick_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tick_counter #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clear  (ack_i),
    .run    (~irq),
    .at_end (at_end)
  );

  tick_irq_hold u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ack     (ack_i),
    .expired (at_end),
    .irq     (irq)
  );

  assign irq_o = irq;

`ifndef SYNTHESIS
  initial begin
    if (PERIOD_CYCLES < 2)
      $display("interval_irq_timer: PERIOD_CYCLES below 2 is unsupported (R9)");
  end
  // R1: no interrupt while the block is held in reset
  p_reset_low_r1: assert property (@(posedge clk) !rst_int_n |-> !irq_o);
`endif
endmodule

// File: tb/sim_interval_irq_timer.sv
`timescale 1ns/1ps
module sim_interval_irq_timer;
  localparam int unsigned P  = 16;
  localparam int unsigned P2 = 2;

  logic clk;
  logic rst_n;
  logic ack;
  logic irq;
  logic ack2;
  logic irq2;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  interval_irq_timer #(.PERIOD_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_i(ack), .irq_o(irq));
  interval_irq_timer #(.PERIOD_CYCLES(P2)) u1 (
    .clk(clk), .rst_n(rst_n), .ack_i(ack2), .irq_o(irq2));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  // Called right after the edge that sampled the last acknowledge
  task automatic expect_period(input string tag);
    step(P - 1);
    chk(irq, 1'b0, {tag, " low one edge before expiry"});
    step(1);
    chk(irq, 1'b1, {tag, " high at expiry"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ack = 1'b0; ack2 = 1'b0;
    step(3);
    chk(irq, 1'b0, "R1 low in reset");
    chk(irq2, 1'b0, "R1 low in reset (min period)");
    #3 rst_n = 1'b1;
    step(P + 1);
    chk(irq, 1'b0, "R1 low before first expiry");
    step(1);
    chk(irq, 1'b1, "R1 first expiry at P+2 edges");
  endtask

  task automatic t_hold();
    step(3 * P);
    chk(irq, 1'b1, "R3 pending interrupt held without ack");
    pulse_ack();
    chk(irq, 1'b0, "R4 ack clears interrupt");
    expect_period("R5 full period after long wait, R2");
  endtask

  task automatic t_idle_ack();
    pulse_ack();
    step(P / 2);
    chk(irq, 1'b0, "R6 idle before second ack");
    pulse_ack();
    expect_period("R6 restart from idle ack");
  endtask

  task automatic t_ack_on_expiry();
    pulse_ack();
    step(P - 1);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk(irq, 1'b0, "R7 ack wins on expiry edge");
    expect_period("R7 full period after collision");
  endtask

  task automatic t_held_ack();
    ack = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk(irq, 1'b0, "R8 low while ack held");
    end
    ack = 1'b0;
    expect_period("R8 period from last ack edge");
  endtask

  task automatic t_min_period();
    chk(irq2, 1'b1, "R9 min period pending since reset");
    ack2 = 1'b1;
    step(1);
    ack2 = 1'b0;
    chk(irq2, 1'b0, "R9 ack clears min period");
    step(1);
    chk(irq2, 1'b0, "R9 low one edge after ack");
    step(1);
    chk(irq2, 1'b1, "R9 high two edges after ack");
    step(4);
    chk(irq2, 1'b1, "R9 held without ack");
  endtask

  initial begin
    t_reset();
    t_hold();
    t_idle_ack();
    t_ack_on_expiry();
    t_held_ack();
    t_min_period();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule